// File: doc/BRIEF.md
# Serialized Two-Read Two-Write Register File Model

This block models a register file with two read ports and two write ports, for use inside a cycle-accounting performance model that runs on an FPGA. It does not build true multiport storage. It keeps every register in one single-ported synchronous RAM and shares that RAM over several fabric clocks. Each group of fabric clocks stands for one model cycle.

A model cycle begins with a one-clock `start` pulse while the block is idle. The pulse captures every port's enable, address and write data. The block then services the enabled operations one per clock, in a fixed order: read port 0, read port 1, write port 0, write port 1. Disabled ports cost no clocks. When every captured request has been serviced, the block drops `busy` and raises `done` for one clock, and the read results are valid at that point.

In model time, reads have zero latency: they return the contents from before any write of the same model cycle. With two operations enabled, a model cycle costs three fabric clocks including the closing clock.

Top module: `rfm_top`

## Requirements
- R1: After reset, `busy` and `done` are low and both read data outputs are zero.
- R2: A `start` pulse seen while `busy` is low is accepted. It captures all port inputs, and `busy` is high after that edge. `start`, enables, addresses and data presented while `busy` is high are ignored.
- R3: A read returns the register's value from before the writes of the same model cycle, even when a write in that model cycle targets the same address.
- R4: When both write ports are enabled with the same address, the register afterwards holds write port 1's data.
- R5: With n enabled ports (0 to 4), `done` is high for exactly one clock period. That period begins at the (n+1)th rising edge after the edge that accepted `start`.
- R6: A disabled read port leaves its data output at its previous value.
- R7: A disabled write port does not modify any register.
- R8: `busy` and `done` are never high together, and `done` only follows a clock with `busy` high.
- R9: A model cycle with no port enabled completes with `done` at the first edge after acceptance.
- R10: The read data outputs change only at edges where `busy` was high before the edge.
- R11: An enabled read port's output equals the register at its captured address, as updated by all earlier model cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a model cycle (accepted when idle) |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | ADDR_W | Read port 0 register index |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | ADDR_W | Read port 1 register index |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W | Write port 0 register index |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable (wins on equal address) |
| wr1_addr | input | ADDR_W | Write port 1 register index |
| wr1_data | input | DATA_W | Write port 1 data |
| busy | output | 1 | Model cycle in progress |
| done | output | 1 | One-clock pulse: model cycle finished, read data valid |
| rd0_data | output | DATA_W | Read port 0 result |
| rd1_data | output | DATA_W | Read port 1 result |

## Verification
The bench fires model cycles that read and write the same register, so a design that serviced a write before the reads would hand back the new value where the old one is expected. It also drives both writes to one address, which catches a design that applies the ports in the wrong order and leaves port 0's data behind. It clears enables to check that skipped ports cost no clocks: a design that spent a slot on them would raise `done` late. The bench checks that disabled ports leave outputs and storage untouched, and it changes every input mid-cycle to show that a design that sampled inputs after acceptance would corrupt its results.

// File: rtl/rfm_pkg.sv
// Shared constants and types for the serialized register file model.
// Operation slot indices define the service order (lower index first).
package rfm_pkg;
    localparam int OP_COUNT = 4;
    localparam int OP_RD0   = 0;
    localparam int OP_RD1   = 1;
    localparam int OP_WR0   = 2;
    localparam int OP_WR1   = 3;
    localparam int RD_PORTS = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/rfm_sram.sv
// Single-port synchronous RAM holding every modeled register.
// Assumes at most one access per clock; read data appear after the edge.
// No reset on contents: the model starts with undefined registers.
module rfm_sram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write or registered read, one access per clock.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/rfm_op_picker.sv
// Picks the lowest-index pending operation as a one-hot grant.
// Assumes the slot index order is the required service order.
module rfm_op_picker #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant,
    output logic         any
);
    // Lowest set bit wins.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfm_read_capture.sv
// Holds each read port's result. A read issued at one edge has its RAM
// data captured at the following edge; other ports keep their value.
module rfm_read_capture #(
    parameter int DATA_W = 32,
    parameter int NPORT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORT-1:0]  issue,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] data [NPORT]
);
    logic [NPORT-1:0] issued_q;

    // Remember which port's read is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) issued_q <= '0;
        else        issued_q <= issue;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Latch RAM data for this port one edge after its read.
        always_ff @(posedge clk) begin
            if (!rst_n)           data[p] <= '0;
            else if (issued_q[p]) data[p] <= ram_q;
        end
    end
endmodule

// File: rtl/rfm_top.sv
// Serialized 2-read/2-write register file model. One start pulse opens a
// model cycle; enabled ports are serviced one per clock, reads first, then
// write port 0, then write port 1; a closing clock raises done.
// Assumes start is only meaningful while busy is low.
module rfm_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd0_en,
    input  logic [ADDR_W-1:0] rd0_addr,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    input  logic              wr0_en,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic [DATA_W-1:0] wr1_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd0_data,
    output logic [DATA_W-1:0] rd1_data
);
    import rfm_pkg::*;

    phase_e                phase;
    logic [OP_COUNT-1:0]   pend;
    logic [OP_COUNT-1:0]   grant;
    logic                  any_pend;
    logic [ADDR_W-1:0]     addr_q [OP_COUNT];
    logic [DATA_W-1:0]     wd0_q, wd1_q;
    logic                  ram_we, ram_re;
    logic [ADDR_W-1:0]     ram_addr;
    logic [DATA_W-1:0]     ram_wd, ram_q;
    logic [RD_PORTS-1:0]   rd_issue;
    logic [DATA_W-1:0]     rd_out [RD_PORTS];
    logic                  running;

    assign running = (phase == PH_RUN);
    assign busy    = running;

    rfm_op_picker #(.N(OP_COUNT)) u_pick (
        .pend  (pend),
        .grant (grant),
        .any   (any_pend)
    );

    // Model-cycle sequencing: capture on start, retire one op per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            pend  <= '0;
            done  <= 1'b0;
            wd0_q <= '0;
            wd1_q <= '0;
            for (int i = 0; i < OP_COUNT; i++) addr_q[i] <= '0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    pend           <= {wr1_en, wr0_en, rd1_en, rd0_en};
                    addr_q[OP_RD0] <= rd0_addr;
                    addr_q[OP_RD1] <= rd1_addr;
                    addr_q[OP_WR0] <= wr0_addr;
                    addr_q[OP_WR1] <= wr1_addr;
                    wd0_q          <= wr0_data;
                    wd1_q          <= wr1_data;
                    phase          <= PH_RUN;
                end
            end else if (any_pend) begin
                pend <= pend & ~grant;
            end else begin
                phase <= PH_IDLE;
                done  <= 1'b1;
            end
        end
    end

    // Steer the granted operation onto the single RAM port.
    always_comb begin
        ram_addr = '0;
        for (int i = 0; i < OP_COUNT; i++) begin
            if (grant[i]) ram_addr = addr_q[i];
        end
        rd_issue = running ? grant[OP_RD1:OP_RD0] : '0;
        ram_re   = |rd_issue;
        ram_we   = running && (grant[OP_WR0] || grant[OP_WR1]);
        ram_wd   = grant[OP_WR1] ? wd1_q : wd0_q;
    end

    rfm_sram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_q)
    );

    rfm_read_capture #(.DATA_W(DATA_W), .NPORT(RD_PORTS)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (rd_issue),
        .ram_q (ram_q),
        .data  (rd_out)
    );

    assign rd0_data = rd_out[0];
    assign rd1_data = rd_out[1];
endmodule

// File: rtl/rfm_checker.sv
// Protocol checks on the model's handshake and read outputs.
module rfm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd0_data,
    input logic [DATA_W-1:0] rd1_data
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R5
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(rd0_data) && $stable(rd1_data)));
endmodule

bind rfm_top rfm_checker #(.DATA_W(DATA_W)) u_rfm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data)
);

// File: tb/tb_rfm_top.sv
// Bench: behavioural register array plus per-clock expectations of busy,
// done and read data for every model cycle.
module tb_rfm_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NREG = 1 << AW;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd0_en = 0, rd1_en = 0, wr0_en = 0, wr1_en = 0;
    logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, wr0_addr = '0, wr1_addr = '0;
    logic [DW-1:0] wr0_data = '0, wr1_data = '0;
    logic busy, done;
    logic [DW-1:0] rd0_data, rd1_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [DW-1:0] ref_mem [NREG];
    logic [DW-1:0] exp0 = '0, exp1 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfm_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .busy(busy), .done(done), .rd0_data(rd0_data), .rd1_data(rd1_data)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One model cycle. Entered and left just after a falling edge, idle.
    task automatic model_cycle(input bit e_r0, input logic [AW-1:0] a_r0,
                               input bit e_r1, input logic [AW-1:0] a_r1,
                               input bit e_w0, input logic [AW-1:0] a_w0,
                               input logic [DW-1:0] d_w0,
                               input bit e_w1, input logic [AW-1:0] a_w1,
                               input logic [DW-1:0] d_w1,
                               input bit scramble, input string req);
        int n;
        n = int'(e_r0) + int'(e_r1) + int'(e_w0) + int'(e_w1);
        // reference: reads see values before this cycle's writes (R3)
        if (e_r0) exp0 = ref_mem[a_r0];
        if (e_r1) exp1 = ref_mem[a_r1];
        if (e_w0) ref_mem[a_w0] = d_w0;
        if (e_w1) ref_mem[a_w1] = d_w1;  // port 1 last: wins (R4)
        rd0_en = e_r0; rd0_addr = a_r0; rd1_en = e_r1; rd1_addr = a_r1;
        wr0_en = e_w0; wr0_addr = a_w0; wr0_data = d_w0;
        wr1_en = e_w1; wr1_addr = a_w1; wr1_data = d_w1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            // R2: everything below must be ignored while busy
            start = 1'b1;
            rd0_en = ~e_r0; rd1_en = ~e_r1; wr0_en = 1'b1; wr1_en = 1'b1;
            rd0_addr = ~a_r0; rd1_addr = ~a_r1; wr0_addr = a_r0; wr1_addr = a_r1;
            wr0_data = 32'hDEAD_0000; wr1_data = 32'hDEAD_1111;
        end
        chk(busy === 1'b1, "R2", "busy after accept", {31'b0, busy}, 1);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            start = 1'b0;
            wr0_en = 1'b0; wr1_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R5", "busy mid-cycle",
                {30'b0, busy, done}, 32'h2);
        end
        @(negedge clk);
        start = 1'b0;
        wr0_en = 1'b0; wr1_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, req, "done at n+1 edges (R5)",
            {30'b0, busy, done}, 32'h1);
        chk(rd0_data === exp0, req, "rd0_data (R11/R6)", rd0_data, exp0);
        chk(rd1_data === exp1, req, "rd1_data (R11/R6)", rd1_data, exp1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R5", "done single pulse",
            {30'b0, busy, done}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset",
            {30'b0, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset",
            {30'b0, busy, done}, 32'h0);
        chk(rd0_data === '0, "R1", "rd0_data reset", rd0_data, 0);
        chk(rd1_data === '0, "R1", "rd1_data reset", rd1_data, 0);

        // Initialise every register, two per model cycle.
        for (int i = 0; i < NREG; i += 2)
            model_cycle(0, 0, 0, 0, 1, AW'(i), 32'h1000 + i,
                        1, AW'(i + 1), 32'h1000 + i + 1, 0, "R11");

        // R3: read and write the same register in one model cycle
        model_cycle(1, 5, 1, 6, 1, 5, 32'hAAAA_0005, 1, 6, 32'hBBBB_0006, 0, "R3");
        model_cycle(1, 5, 1, 6, 0, 0, 0, 0, 0, 0, 0, "R3");

        // R4: both writes to one address, port 1 must win
        model_cycle(0, 0, 0, 0, 1, 9, 32'h0000_0A0A, 1, 9, 32'h0000_1B1B, 0, "R4");
        model_cycle(1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // R7: disabled write port carries data but must not store it
        model_cycle(0, 0, 0, 0, 0, 12, 32'hBAD0_BAD0, 1, 13, 32'h0000_D00D, 0, "R7");
        model_cycle(1, 12, 1, 13, 0, 0, 0, 0, 0, 0, 0, "R7");

        // R6: one read disabled keeps its previous output
        model_cycle(0, 20, 1, 21, 0, 0, 0, 0, 0, 0, 0, "R6");

        // R9: nothing enabled
        model_cycle(0, 3, 0, 4, 0, 0, 0, 0, 0, 0, 0, "R9");

        // R2: inputs and start changed while busy are ignored
        model_cycle(1, 7, 1, 8, 1, 7, 32'h7777_0007, 1, 8, 32'h8888_0008, 1, "R2");
        model_cycle(1, 7, 1, 8, 0, 0, 0, 0, 0, 0, 0, "R2");

        // Mixed patterns with random enables, addresses and data (R11).
        for (int t = 0; t < 300; t++) begin
            logic [3:0] en;
            en = 4'($urandom());
            model_cycle(en[0], AW'($urandom()), en[1], AW'($urandom()),
                        en[2], AW'($urandom()), $urandom(),
                        en[3], AW'($urandom()), $urandom(),
                        (t % 7) == 3, "R11");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule